// File: doc/BRIEF.md
# SPI Byte Receiver with Frame Realignment

This block is a receive-only SPI slave. It samples the serial clock, the serial data input and the active-low select through synchronizers clocked by a faster system clock. It shifts data in on rising serial-clock edges, most significant bit first, and presents each completed byte on a parallel output with a one-cycle valid strobe.

A lost or extra clock pulse leaves a shift counter off by some bits, and a slave whose select is held permanently active never sees a select edge to correct it. The receiver therefore has two more ways to return its bit counter to a byte boundary. The first is an idle timer that restarts on every serial-clock edge and drops the partial byte when the clock has been silent for a programmable number of system cycles. The second treats a data-line transition with no clock activity as a marker. Each of these can be enabled separately. Releasing the select always resets the counter. Whenever bits are thrown away, a one-cycle flag reports it.

Top module: `spi_resync_rx`

## Requirements
- R1: After reset, `rxValid` and `resyncPulse` are 0 and `rxData` is 0.
- R2: While selected (`ssnIn` low), each rising `sckIn` edge samples `mosiIn`. Bits are taken most significant first. On the 8th sampled bit, `rxData` is loaded with the byte and `rxValid` is high for exactly one cycle. `rxData` then holds until the next byte.
- R3: `rxValid` is visible at the third falling system-clock edge after the 8th rising `sckIn` level is driven: two synchronizer stages plus one output register.
- R4: While `ssnIn` is high, `sckIn` and `mosiIn` have no effect and no byte is produced. Releasing select clears the bit counter, so the first rising edge after select returns is bit 7 of a new byte.
- R5: With `enTimeout` high and select active, when `idleLimit` (at least 1) consecutive system cycles pass with no synchronized `sckIn` edge of either polarity, the bit counter is cleared.
- R6: The idle timer restarts on every `sckIn` edge, not only at byte ends. A partial byte followed by silence is discarded. Traffic whose edge gaps are shorter than `idleLimit` is never disturbed.
- R7: With `enMarker` high and select active, a synchronized `mosiIn` transition clears the bit counter if two conditions hold: no `sckIn` edge is detected in the same cycle, and more than `GUARD_CYC` cycles have passed since the last `sckIn` edge. Data changes inside that guard window are ignored.
- R8: With `enTimeout` and `enMarker` both low, neither clock silence nor data-line toggles disturb a partially received byte.
- R9: `resyncPulse` is high for one cycle exactly when a clear from any source discards 1 to 7 already-received bits. A clear at a byte boundary does not raise it, and it never coincides with `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the master (mode 0) |
| mosiIn | input | 1 | Serial data from the master |
| ssnIn | input | 1 | Active-low slave select |
| idleLimit | input | TIMER_W | Silent system cycles before a timeout clear |
| enTimeout | input | 1 | Enables the idle-clock realignment |
| enMarker | input | 1 | Enables the data-toggle marker realignment |
| rxData | output | DATA_W | Last completed byte |
| rxValid | output | 1 | One-cycle strobe when a byte completes |
| resyncPulse | output | 1 | One-cycle strobe when a partial byte is discarded |

## Verification
An error in the bit counter does not show up as a bad flag. It shows up as a byte whose bits are shifted, and it surfaces at the next `rxValid`, which can come up to eight serial clocks late. A partial count that is wrongly kept or wrongly cleared is caught sooner: `resyncPulse` appears or is missing three system cycles after the clear source reaches the pins. The bench compares all outputs against a behavioural model every cycle. This exposes timer or guard counts that are off by one at the exact cycle they diverge, rather than only at the next byte.

// File: rtl/spi_resync_pkg.sv
package spi_resync_pkg;
  // Strobes from the control block to the datapath, one set per system cycle
  typedef struct packed {
    logic clearBits;  // drop the partial byte, counter back to zero
    logic shiftBit;   // take dataBit into the shift register
    logic dataBit;    // synchronized serial data level
  } rx_strobe_t;
endpackage

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_resync_pkg::*;
#(
  parameter int TIMER_W   = 16,
  parameter int GUARD_CYC = 3,
  parameter int SYNC_LEN  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sckIn,
  input  logic               mosiIn,
  input  logic               ssnIn,
  input  logic [TIMER_W-1:0] idleLimit,
  input  logic               enTimeout,
  input  logic               enMarker,
  output rx_strobe_t         strobe
);
  localparam int GUARD_W = $clog2(GUARD_CYC + 1);

  logic [SYNC_LEN-1:0] sckPipe, mosiPipe, ssnPipe;
  logic sckLast, mosiLast;
  logic sckNow, mosiNow, selected;
  logic sckEdge, sckRise, mosiEdge;
  logic [TIMER_W-1:0] idleCnt;
  logic [GUARD_W-1:0] guardCnt;
  logic guardOpen, timeoutHit, markerHit;

  // synchronizers and one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckPipe  <= '0;
      mosiPipe <= '0;
      ssnPipe  <= '1;
      sckLast  <= 1'b0;
      mosiLast <= 1'b0;
    end else begin
      sckPipe  <= {sckPipe[SYNC_LEN-2:0], sckIn};
      mosiPipe <= {mosiPipe[SYNC_LEN-2:0], mosiIn};
      ssnPipe  <= {ssnPipe[SYNC_LEN-2:0], ssnIn};
      sckLast  <= sckPipe[SYNC_LEN-1];
      mosiLast <= mosiPipe[SYNC_LEN-1];
    end
  end

  assign sckNow   = sckPipe[SYNC_LEN-1];
  assign mosiNow  = mosiPipe[SYNC_LEN-1];
  assign selected = ~ssnPipe[SYNC_LEN-1];
  assign sckEdge  = sckNow ^ sckLast;
  assign sckRise  = sckNow & ~sckLast;
  assign mosiEdge = mosiNow ^ mosiLast;

  // idle timer, restarted on every clock edge, saturates at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (sckEdge || !selected) begin
      idleCnt <= '0;
    end else if (idleCnt != idleLimit) begin
      idleCnt <= idleCnt + TIMER_W'(1);
    end
  end

  // guard window after each clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guardCnt <= '0;
    end else if (sckEdge) begin
      guardCnt <= GUARD_W'(GUARD_CYC);
    end else if (guardCnt != '0) begin
      guardCnt <= guardCnt - GUARD_W'(1);
    end
  end

  assign guardOpen  = (guardCnt == '0);
  assign timeoutHit = enTimeout & selected & ~sckEdge &
                      (idleCnt == idleLimit - TIMER_W'(1));
  assign markerHit  = enMarker & selected & mosiEdge & ~sckEdge & guardOpen;

  always_comb begin
    strobe.clearBits = ~selected | timeoutHit | markerHit;
    strobe.shiftBit  = selected & sckRise;
    strobe.dataBit   = mosiNow;
  end
endmodule

// File: rtl/spi_rx_datapath.sv
module spi_rx_datapath
  import spi_resync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_strobe_t        strobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              resyncPulse
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;
  logic              lastBit;

  assign shiftNext = {shiftReg[DATA_W-2:0], strobe.dataBit};
  assign lastBit   = (bitCnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt      <= '0;
      shiftReg    <= '0;
      rxData      <= '0;
      rxValid     <= 1'b0;
      resyncPulse <= 1'b0;
    end else begin
      rxValid     <= 1'b0;
      resyncPulse <= 1'b0;
      if (strobe.clearBits) begin
        resyncPulse <= (bitCnt != '0);
        bitCnt      <= '0;
      end else if (strobe.shiftBit) begin
        shiftReg <= shiftNext;
        if (lastBit) begin
          rxData  <= shiftNext;
          rxValid <= 1'b1;
          bitCnt  <= '0;
        end else begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_resync_rx.sv
module spi_resync_rx
  import spi_resync_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TIMER_W   = 16,
  parameter int GUARD_CYC = 3,
  parameter int SYNC_LEN  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sckIn,
  input  logic               mosiIn,
  input  logic               ssnIn,
  input  logic [TIMER_W-1:0] idleLimit,
  input  logic               enTimeout,
  input  logic               enMarker,
  output logic [DATA_W-1:0]  rxData,
  output logic               rxValid,
  output logic               resyncPulse
);
  rx_strobe_t strobe;

  spi_rx_ctrl #(
    .TIMER_W(TIMER_W), .GUARD_CYC(GUARD_CYC), .SYNC_LEN(SYNC_LEN)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .sckIn(sckIn), .mosiIn(mosiIn), .ssnIn(ssnIn),
    .idleLimit(idleLimit), .enTimeout(enTimeout), .enMarker(enMarker),
    .strobe(strobe)
  );

  spi_rx_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .rxData(rxData), .rxValid(rxValid), .resyncPulse(resyncPulse)
  );
endmodule

// File: rtl/spi_resync_rx_chk.sv
module spi_resync_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic ssnIn,
  input logic rxValid,
  input logic resyncPulse
);
  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  // R9
  resync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resyncPulse |=> !resyncPulse);

  // R9
  resync_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxValid && resyncPulse));

  // R4
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ssnIn, 1) && $past(ssnIn, 2) && $past(ssnIn, 3)) |-> !rxValid);
endmodule

bind spi_resync_rx spi_resync_rx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ssnIn(ssnIn),
  .rxValid(rxValid), .resyncPulse(resyncPulse)
);

// File: tb/test_spi_resync_rx.sv
module test_spi_resync_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sckIn = 1'b0, mosiIn = 1'b0, ssnIn = 1'b1;
  logic [15:0] idleLimit = 16'd20;
  logic enTimeout = 1'b0, enMarker = 1'b0;
  logic [7:0] rxData;
  logic rxValid, resyncPulse;

  int total = 0, bad = 0;
  int validCnt = 0, resyncCnt = 0;
  string phase = "R1 reset";
  logic [7:0] expQ[$];

  localparam int GUARD = 3;

  always #2 clk = ~clk;

  spi_resync_rx i_spi_resync_rx (
    .clk(clk), .rst_n(rst_n), .sckIn(sckIn), .mosiIn(mosiIn), .ssnIn(ssnIn),
    .idleLimit(idleLimit), .enTimeout(enTimeout), .enMarker(enMarker),
    .rxData(rxData), .rxValid(rxValid), .resyncPulse(resyncPulse)
  );

  // behavioural reference model
  bit mSck[3], mMosi[3], mSsn[3];   // index 0,1 synchronizer, 2 history
  int mGuard, mIdle, mBits, mSh;
  logic [7:0] eData;
  bit eValid, eResync;

  always @(posedge clk) begin
    if (!rst_n) begin
      mSck = '{0, 0, 0}; mMosi = '{0, 0, 0}; mSsn = '{1, 1, 1};
      mGuard = 0; mIdle = 0; mBits = 0; mSh = 0;
      eData = 0; eValid = 0; eResync = 0;
    end else begin
      bit sel, edgeS, riseS, edgeM, tmo, mark;
      sel   = !mSsn[1];
      edgeS = mSck[1] != mSck[2];
      riseS = mSck[1] && !mSck[2];
      edgeM = mMosi[1] != mMosi[2];
      tmo   = enTimeout && sel && !edgeS && (mIdle == int'(idleLimit) - 1);
      mark  = enMarker && sel && edgeM && !edgeS && (mGuard == 0);
      eValid = 0; eResync = 0;
      if (!sel || tmo || mark) begin
        eResync = (mBits != 0);
        mBits = 0;
      end else if (riseS) begin
        mSh = ((mSh << 1) | int'(mMosi[1])) & 255;
        if (mBits == 7) begin
          eData = 8'(mSh); eValid = 1; mBits = 0;
        end else mBits++;
      end
      if (edgeS) mGuard = GUARD; else if (mGuard > 0) mGuard--;
      if (edgeS || !sel) mIdle = 0;
      else if (mIdle != int'(idleLimit)) mIdle++;
      mSck[2] = mSck[1];   mSck[1] = mSck[0];   mSck[0] = sckIn;
      mMosi[2] = mMosi[1]; mMosi[1] = mMosi[0]; mMosi[0] = mosiIn;
      mSsn[2] = mSsn[1];   mSsn[1] = mSsn[0];   mSsn[0] = ssnIn;
    end
  end

  // per-cycle comparison and event monitor
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (rxValid !== eValid || resyncPulse !== eResync || rxData !== eData) begin
        bad++;
        $display("FAIL %s: model mismatch valid=%b/%b resync=%b/%b data=%h/%h",
                 phase, rxValid, eValid, resyncPulse, eResync, rxData, eData);
      end
      if (rxValid === 1'b1) begin
        validCnt++;
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R2 %s: unexpected byte got=%h expected=none", phase, rxData);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          if (rxData !== e) begin
            bad++;
            $display("FAIL R2 %s: byte got=%h expected=%h", phase, rxData, e);
          end
        end
      end
      if (resyncPulse === 1'b1) resyncCnt++;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends the n most significant bits of v, mode 0, data moves 1 cycle after SCK falls
  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mosiIn = v[7-i];
      waitClk(3);
      sckIn = 1'b1;
      waitClk(4);
      sckIn = 1'b0;
    end
  endtask

  task automatic startPhase(input string p);
    phase = p;
    validCnt = 0;
    resyncCnt = 0;
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, got=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitClk(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 rxValid after reset", int'(rxValid), 0);
    check("R1 resyncPulse after reset", int'(resyncPulse), 0);
    check("R1 rxData after reset", int'(rxData), 0);

    // R2 / R3 / R6 / R7: clean traffic with all sources enabled
    startPhase("R2 R3 R6 R7 clean bytes");
    enTimeout = 1'b1; enMarker = 1'b1; idleLimit = 16'd20;
    ssnIn = 1'b0;
    waitClk(6);
    expQ.push_back(8'hA5);
    sendBits(8'hA5, 7);
    @(negedge clk);
    mosiIn = 1'b1;
    waitClk(3);
    sckIn = 1'b1;
    waitClk(2);
    check("R3 no valid two cycles after last rise", int'(rxValid), 0);
    waitClk(1);
    check("R3 valid three cycles after last rise", int'(rxValid), 1);
    waitClk(1);
    check("R2 valid lasts one cycle", int'(rxValid), 0);
    check("R2 data held", int'(rxData), 'hA5);
    sckIn = 1'b0;
    expQ.push_back(8'h3C);
    sendBits(8'h3C, 8);
    waitClk(30);
    check("R2 two bytes seen", validCnt, 2);
    check("R6 R7 no resync on clean traffic", resyncCnt, 0);

    // R5 / R6: partial byte then silence
    startPhase("R5 R6 timeout");
    sendBits(8'hE0, 3);
    waitClk(30);
    check("R5 R6 partial byte dropped by timeout", resyncCnt, 1);
    expQ.push_back(8'h81);
    sendBits(8'h81, 8);
    waitClk(10);
    check("R5 realigned byte received", validCnt, 1);

    // R8: both fallback sources off
    startPhase("R8 sources disabled");
    enTimeout = 1'b0; enMarker = 1'b0;
    sendBits(8'hA0, 3);
    waitClk(40);
    mosiIn = ~mosiIn;
    waitClk(10);
    mosiIn = ~mosiIn;
    waitClk(10);
    expQ.push_back(8'hB3);
    sendBits(8'h98, 5);
    waitClk(10);
    check("R8 no resync with sources off", resyncCnt, 0);
    check("R8 partial bytes joined", validCnt, 1);

    // R7 / R9: data-line marker
    startPhase("R7 R9 marker");
    enMarker = 1'b1;
    sendBits(8'hF0, 4);
    waitClk(10);
    mosiIn = ~mosiIn;
    waitClk(10);
    check("R7 R9 marker drops partial byte", resyncCnt, 1);
    expQ.push_back(8'h5A);
    sendBits(8'h5A, 8);
    waitClk(10);
    check("R7 byte after marker", validCnt, 1);
    check("R9 single resync in marker phase", resyncCnt, 1);

    // R4: select released mid-byte
    startPhase("R4 deselect");
    enTimeout = 1'b1;
    sendBits(8'hC0, 5);
    ssnIn = 1'b1;
    waitClk(6);
    sendBits(8'hFF, 8);
    sendBits(8'h00, 8);
    waitClk(6);
    check("R4 no byte while deselected", validCnt, 0);
    check("R4 R9 partial byte dropped on deselect", resyncCnt, 1);
    ssnIn = 1'b0;
    waitClk(6);
    expQ.push_back(8'h77);
    sendBits(8'h77, 8);
    waitClk(10);
    check("R4 byte after reselect", validCnt, 1);
    check("R2 all expected bytes arrived", expQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule